// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one data byte at a time into an asynchronous serial frame on an idle-high line. A host hands over a byte through a valid/ready handshake. An external baud generator supplies a single-cycle enable, `tick_i`, and the transmitter advances its bit timing only on cycles where that enable is high. Each frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then one, one-and-a-half or two high stop periods.

A 7-bit control input sets the frame format. Its fields select the data length, the stop length, whether parity is sent and how it is formed (odd, even, or held at a fixed level), and a break request. The transmitter copies the format fields when it accepts a byte, so the host may change them for the next byte while the current frame is still going out. The break request is the exception: it acts at once. It pulls the line low, discards any frame in progress and refuses new bytes until it is released.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, with `ctrl_i[6]` low, `tx_o` is 1 and `ready_o` is 1.
- R2: A byte is accepted on a cycle where `valid_i` and `ready_o` are both high. From the next cycle `tx_o` is 0 for a start bit of TICKS_PER_BIT ticks, and `ready_o` stays 0 until the frame ends.
- R3: `ctrl_i[1:0]` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. The data bits follow the start bit, least significant bit first. Each bit lasts TICKS_PER_BIT ticks, and unused upper bits of `data_i` are not sent.
- R4: With `ctrl_i[3]` = 0 no parity bit is sent, and the stop period follows the last data bit directly.
- R5: With `ctrl_i[3]` = 1 and `ctrl_i[5]` = 0, a parity bit follows the data. With `ctrl_i[4]` = 0 the count of ones over the data bits and the parity bit is odd; with `ctrl_i[4]` = 1 it is even.
- R6: With `ctrl_i[3]` = 1 and `ctrl_i[5]` = 1, the parity bit is a fixed 1 when `ctrl_i[4]` = 0 and a fixed 0 when `ctrl_i[4]` = 1.
- R7: With `ctrl_i[2]` = 0 the stop period is high for TICKS_PER_BIT ticks at every data length.
- R8: With `ctrl_i[2]` = 1 the stop period is high for 3*TICKS_PER_BIT/2 ticks when the data length is 5, and for 2*TICKS_PER_BIT ticks when it is 6, 7 or 8.
- R9: `ready_o` returns to 1 in the cycle after the tick that ends the stop period. Whenever `ready_o` is 1 and break was not set in the previous cycle, `tx_o` is 1.
- R10: The format fields are taken from `ctrl_i` in the cycle the byte is accepted. Changing bits 5:0 during a frame does not alter that frame.
- R11: While `ctrl_i[6]` = 1, `ready_o` is 0, and `tx_o` is 0 from the next cycle onward. Any frame in progress is dropped and does not resume. One cycle after the bit clears, `tx_o` is 1 and the block is ready.
- R12: In a cycle with `tick_i` low, and with no acceptance and no break, `tx_o` keeps its level in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Baud tick enable, one cycle wide |
| ctrl_i | input | 7 | Frame format: [1:0] length, [2] long stop, [3] parity enable, [4] parity select, [5] fixed parity, [6] break |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | Byte on `data_i` is offered |
| ready_o | output | 1 | Transmitter can accept a byte |
| tx_o | output | 1 | Serial line, idle high |

## Verification
The bench builds the block with TICKS_PER_BIT = 4 and issues a baud tick every third clock. A data bit therefore lasts twelve clocks and a 1.5 stop period lasts two ticks past a whole bit, so every data length, parity mode and stop length fits into a short run. Frames are sent back to back with the control input changed during flight. The tick is stalled in the middle of a frame. A break is raised partway through a frame, held while a byte is offered, and then released.

// File: rtl/uft_pkg.sv
package uft_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  // field order matches the control input bit positions
  typedef struct packed {
    logic       brk;
    logic       stick;
    logic       par_sel;
    logic       par_en;
    logic       stop_long;
    logic [1:0] len;
  } frame_cfg_t;

endpackage

// File: rtl/uft_parity.sv
module uft_parity
  import uft_pkg::*;
(
  input  logic [7:0] data_i,
  input  frame_cfg_t cfg_i,
  output logic       par_o
);

  logic [7:0] mask;
  logic       ones_odd;

  always_comb begin
    mask = 8'h1f;
    for (int i = 5; i < 8; i++) begin
      if (int'(cfg_i.len) >= i - 4) mask[i] = 1'b1;
    end
    ones_odd = ^(data_i & mask);
    if (cfg_i.stick) par_o = ~cfg_i.par_sel;
    else if (cfg_i.par_sel) par_o = ones_odd;
    else par_o = ~ones_odd;
  end

endmodule

// File: rtl/uft_bit_timer.sv
module uft_bit_timer #(
  parameter int unsigned CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i || !run_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/uft_sequencer.sv
module uft_sequencer
  import uft_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       abort_i,
  input  logic       accept_i,
  input  logic       bit_done_i,
  input  logic [7:0] data_i,
  input  frame_cfg_t cfg_i,
  input  logic       par_i,
  output tx_state_e  state_o,
  output frame_cfg_t cfg_o,
  output logic       line_o
);

  tx_state_e  state_q;
  frame_cfg_t cfg_q;
  logic [7:0] shreg_q;
  logic [2:0] idx_q;
  logic       par_q;
  logic [2:0] last_idx;

  assign last_idx = 3'd4 + {1'b0, cfg_q.len};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      shreg_q <= '0;
      idx_q   <= '0;
      par_q   <= 1'b0;
    end else if (abort_i) begin
      state_q <= ST_IDLE;
    end else if (accept_i) begin
      state_q <= ST_START;
      cfg_q   <= cfg_i;
      shreg_q <= data_i;
      idx_q   <= '0;
      par_q   <= par_i;
    end else if (bit_done_i) begin
      case (state_q)
        ST_START: state_q <= ST_DATA;
        ST_DATA: begin
          shreg_q <= {1'b0, shreg_q[7:1]};
          if (idx_q == last_idx) state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
          else idx_q <= idx_q + 1'b1;
        end
        ST_PAR:  state_q <= ST_STOP;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = shreg_q[0];
      ST_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end

  assign state_o = state_q;
  assign cfg_o   = cfg_q;

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uft_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16  // even, at least 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [6:0] ctrl_i,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  output logic       ready_o,
  output logic       tx_o
);

  localparam int unsigned CW       = $clog2(2 * TICKS_PER_BIT + 1);
  localparam int unsigned T_HALF   = TICKS_PER_BIT / 2;
  localparam logic [CW-1:0] LIM_1  = CW'(TICKS_PER_BIT);
  localparam logic [CW-1:0] LIM_15 = CW'(TICKS_PER_BIT + T_HALF);
  localparam logic [CW-1:0] LIM_2  = CW'(2 * TICKS_PER_BIT);

  frame_cfg_t cfg_in, cfg_cur;
  tx_state_e  state;
  logic       accept, bit_done, par_bit, line, brk_q;
  logic [CW-1:0] limit;

  assign cfg_in  = frame_cfg_t'(ctrl_i);
  assign ready_o = (state == ST_IDLE) && !cfg_in.brk;
  assign accept  = valid_i && ready_o;

  always_comb begin
    limit = LIM_1;
    if (state == ST_STOP && cfg_cur.stop_long) limit = (cfg_cur.len == 2'd0) ? LIM_15 : LIM_2;
  end

  uft_parity u_parity (
    .data_i (data_i),
    .cfg_i  (cfg_in),
    .par_o  (par_bit)
  );

  uft_bit_timer #(.CW(CW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state != ST_IDLE),
    .clr_i   (accept),
    .tick_i  (tick_i),
    .limit_i (limit),
    .done_o  (bit_done)
  );

  uft_sequencer u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .abort_i    (cfg_in.brk),
    .accept_i   (accept),
    .bit_done_i (bit_done),
    .data_i     (data_i),
    .cfg_i      (cfg_in),
    .par_i      (par_bit),
    .state_o    (state),
    .cfg_o      (cfg_cur),
    .line_o     (line)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) brk_q <= 1'b0;
    else brk_q <= cfg_in.brk;
  end

  assign tx_o = brk_q ? 1'b0 : line;

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [6:0] ctrl_i,
  input logic       valid_i,
  input logic       ready_o,
  input logic       tx_o
);

  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else past_ok <= 1'b1;
  end

  a_r2_accept_starts_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> !tx_o && !ready_o);

  a_r11_break_forces_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(ctrl_i[6]) |-> !tx_o);

  a_r11_no_ready_in_break: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[6] |-> !ready_o);

  a_r9_ready_means_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && ready_o && !$past(ctrl_i[6]) |-> tx_o);

  a_r12_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !tick_i && !(valid_i && ready_o) && !ctrl_i[6] && !$past(ctrl_i[6])
    |=> $stable(tx_o));

endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .ctrl_i  (ctrl_i),
  .valid_i (valid_i),
  .ready_o (ready_o),
  .tx_o    (tx_o)
);

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
  localparam int TPB = 4;
  localparam int TICK_DIV = 3;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, valid = 1'b0;
  logic [6:0] ctrl = '0;
  logic [7:0] data = '0;
  logic ready, tx;

  int n_cmp = 0, n_bad = 0, frames_done = 0, rdy_bad = 0;
  bit tick_en = 1, mon_en = 1, push_en = 1;

  typedef struct {
    logic [7:0] d;
    logic [6:0] c;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  uart_frame_tx #(.TICKS_PER_BIT(TPB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ctrl_i(ctrl),
    .data_i(data), .valid_i(valid), .ready_o(ready), .tx_o(tx)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic exp_par(logic [7:0] d, logic [6:0] c);
    int ones = 0;
    for (int i = 0; i < 5 + int'(c[1:0]); i++) ones += int'(d[i]);
    if (c[5]) return !c[4];
    if (c[4]) return logic'(ones % 2);
    return logic'(ones % 2 == 0);
  endfunction

  function automatic int stop_ticks(logic [6:0] c);
    if (!c[2]) return TPB;
    if (c[1:0] == 2'd0) return TPB * 3 / 2;
    return 2 * TPB;
  endfunction

  // tick source, changes just after the edge
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(posedge clk);
      #1;
      ph = (ph + 1) % TICK_DIV;
      tick = tick_en && (ph == 0);
    end
  end

  task automatic seg(logic lvl, int len, string req, string what);
    int seen = 0, bad = 0, badv = 0;
    forever begin
      if (tx !== lvl) begin bad++; badv = int'(tx); end
      if (ready !== 1'b0) rdy_bad++;
      if (tick) seen++;
      if (seen == len) break;
      @(negedge clk);
    end
    chk(bad == 0, req, what, bad == 0 ? int'(lvl) : badv, int'(lvl));
    @(negedge clk);
  endtask

  task automatic run_frame(item_t it);
    int nd = 5 + int'(it.c[1:0]);
    rdy_bad = 0;
    seg(1'b0, TPB, "R2", "start bit");
    for (int i = 0; i < nd; i++) seg(it.d[i], TPB, "R3", "data bit");
    if (it.c[3]) seg(exp_par(it.d, it.c), TPB, it.c[5] ? "R6" : "R5", "parity bit");
    seg(1'b1, stop_ticks(it.c), it.c[2] ? "R8" : "R4/R7", "stop period");
    chk(ready === 1'b1, "R9", "ready after stop", int'(ready), 1);
    chk(rdy_bad == 0, "R2", "ready low during frame", rdy_bad, 0);
    frames_done++;
  endtask

  // monitor: pops the scoreboard on each start bit
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && rst_n && tx === 1'b0) begin
        if (q.size() == 0) chk(1'b0, "R9", "start with empty scoreboard", 0, 1);
        else run_frame(q.pop_front());
      end
    end
  end

  task automatic send(logic [7:0] d, logic [6:0] c);
    @(negedge clk);
    ctrl = c; data = d; valid = 1'b1;
    while (ready !== 1'b1) @(negedge clk);
    if (push_en) q.push_back('{d, c});
    @(posedge clk);
    #1 valid = 1'b0;
  endtask

  task automatic wait_idle();
    wait (q.size() == 0);
    @(negedge clk);
    while (ready !== 1'b1) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int bad, exp_frames;
    logic lvl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx === 1'b1, "R1", "tx after reset", int'(tx), 1);
    chk(ready === 1'b1, "R1", "ready after reset", int'(ready), 1);

    // format sweep, back to back
    send(8'h15, 7'h00);
    send(8'ha5, 7'h03);
    send(8'h01, 7'h0b);
    send(8'h01, 7'h1b);
    send(8'h3c, 7'h2a);
    send(8'h3c, 7'h3a);
    send(8'hff, 7'h0c);
    send(8'h2b, 7'h05);
    send(8'h80, 7'h0f);
    send(8'h6e, 7'h16);
    send(8'he6, 7'h09);
    wait_idle();
    chk(frames_done == 11, "R3", "frames seen", frames_done, 11);

    // R10: format changed right after acceptance
    exp_frames = frames_done + 1;
    send(8'h96, 7'h03);
    @(negedge clk);
    ctrl = 7'h3c;
    wait_idle();
    chk(frames_done == exp_frames, "R10", "frame with mid-flight format change", frames_done, exp_frames);

    // R12: tick stalled mid-frame
    send(8'hc9, 7'h0b);
    repeat (40) @(negedge clk);
    tick_en = 0;
    @(negedge clk);
    @(negedge clk);
    lvl = tx;
    bad = 0;
    repeat (60) begin
      @(negedge clk);
      if (tx !== lvl) bad++;
    end
    chk(bad == 0, "R12", "line held without ticks", bad, 0);
    tick_en = 1;
    wait_idle();

    // R11: break during a frame
    push_en = 0;
    mon_en = 0;
    send(8'h55, 7'h03);
    repeat (30) @(negedge clk);
    ctrl = 7'h43;
    @(negedge clk);
    chk(tx === 1'b0, "R11", "tx low under break", int'(tx), 0);
    chk(ready === 1'b0, "R11", "ready low under break", int'(ready), 0);
    data = 8'h0f;
    valid = 1'b1;
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (tx !== 1'b0 || ready !== 1'b0) bad++;
    end
    chk(bad == 0, "R11", "break held with byte offered", bad, 0);
    valid = 1'b0;
    ctrl = 7'h03;
    @(negedge clk);
    chk(tx === 1'b1, "R11", "tx after break release", int'(tx), 1);
    chk(ready === 1'b1, "R11", "ready after break release", int'(ready), 1);
    bad = 0;
    repeat (200) begin
      @(negedge clk);
      if (tx !== 1'b1) bad++;
    end
    chk(bad == 0, "R11", "dropped frame stays dropped", bad, 0);

    // recovery after break
    mon_en = 1;
    push_en = 1;
    exp_frames = frames_done + 1;
    send(8'hc3, 7'h1f);
    wait_idle();
    chk(frames_done == exp_frames, "R11", "frame after break", frames_done, exp_frames);

    finish_run();
  end

endmodule